// File: doc/BRIEF.md
# DS3 Receive Error Performance Monitor

This block watches a DS3 receive stream that an upstream framer has already aligned and keeps six saturating error counters. Bits arrive one per enabled clock cycle, with a marker on the first bit of each M-frame. The block follows the frame geometry itself: 7 subframes of 8 blocks of 85 bits, each block opening with one overhead bit. At each overhead slot it compares the bit with what a healthy frame carries, and at the end of a frame it keeps the payload parity for the next frame's parity checks.

Line-code-violation and excessive-zeros events come from the line decoder as single-cycle pulses and are only counted. A mode input picks the C-bit parity format, which enables the CP-bit and far-end-block-error checks. A second input sets whether M-bit errors are added to the framing error count. A host strobe copies every counter into a snapshot register and restarts the counts in the same cycle.

Top module: `ds3_err_mon`

## Requirements
- R1: Every counter is 16 bits wide, counts up by one per event and holds at 0xFFFF once it reaches that value.
- R2: Each cycle with `lcv_pulse` high adds one to the line code violation count. Each cycle with `exz_pulse` high adds one to the excessive-zeros count. Neither depends on `bit_en`.
- R3: Block overhead bits with block index 1, 3, 5 and 7 (index 0 is the first block of a subframe) are F bits expected as 1, 0, 0, 1. Each F bit that differs adds one to the framing count.
- R4: The first overhead bits of subframes 5, 6 and 7 (counting from 1) are M bits expected as 0, 1, 0. When `fm_combined` is 1, each M bit that differs adds one to the framing count. When it is 0, M bits are not counted.
- R5: The first overhead bits of subframes 3 and 4 are P bits. Each must equal the XOR of all payload bits of the previous M-frame. A frame where either differs adds exactly one to the parity count. No check is made until one complete frame has been seen since alignment.
- R6: With `cbit_mode` = 1, the overhead bits at block indices 2, 4 and 6 of subframe 3 are compared with the same previous-frame parity. Any mismatch adds exactly one per frame to the CP count, under the same one-frame rule as R5.
- R7: With `cbit_mode` = 1, a frame in which any of the overhead bits at block indices 2, 4 and 6 of subframe 4 is 0 adds exactly one to the far-end block error count.
- R8: With `cbit_mode` = 0, the CP and far-end block error counts never change.
- R9: A cycle with `snap` high copies all six counts to the `shot_*` outputs and restarts each count at 0. If an event arrives in that same cycle, that count restarts at 1. The `shot_*` outputs change only on a snap and are 0 after reset.
- R10: `frame_start` high with `bit_en` marks the current bit as the first bit of an M-frame. Position advances only on cycles with `bit_en` high. Overhead checks start at the first marker after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cbit_mode | input | 1 | 1 selects C-bit parity format, 0 selects asynchronous multiplex format |
| fm_combined | input | 1 | 1 adds M-bit errors to the framing count |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial receive data |
| frame_start | input | 1 | Marks the first bit of an M-frame |
| lcv_pulse | input | 1 | Line code violation event |
| exz_pulse | input | 1 | Excessive-zeros event |
| snap | input | 1 | Snapshot-and-clear strobe |
| shot_lcv | output | 16 | Snapshot of line code violation count |
| shot_exz | output | 16 | Snapshot of excessive-zeros count |
| shot_par | output | 16 | Snapshot of P-bit parity error count |
| shot_frm | output | 16 | Snapshot of framing (F, optionally M) error count |
| shot_febe | output | 16 | Snapshot of far-end block error count |
| shot_cp | output | 16 | Snapshot of CP-bit error count |

## Verification
The assertions check the following on every cycle:
- the counters hold at their ceiling;
- a count moves only on its own event or on a snap;
- a snap leaves each count holding exactly the event of that cycle;
- the snapshot registers stay put between snaps;
- the C-bit counters stay quiet in asynchronous format;
- overhead events occur only on enabled bits.

Only the bench's scenarios show whether each overhead slot is decoded at the right frame position. The same holds for whether P and CP errors are counted once per frame against the parity of the previous frame, whether the first frame after alignment is exempt, and whether idle cycles inside a frame leave the position untouched.

// File: rtl/ds3m_pkg.sv
package ds3m_pkg;
  localparam int CNT_W    = 16;
  localparam int SF_N     = 7;
  localparam int BLK_N    = 8;
  localparam int BLK_BITS = 85;
  localparam int SF_W     = $clog2(SF_N);
  localparam int BLK_W    = $clog2(BLK_N);
  localparam int BNO_W    = $clog2(BLK_BITS);

  localparam int NUM_CNT  = 6;
  localparam int IDX_LCV  = 0;
  localparam int IDX_EXZ  = 1;
  localparam int IDX_PAR  = 2;
  localparam int IDX_FRM  = 3;
  localparam int IDX_FEBE = 4;
  localparam int IDX_CP   = 5;

  typedef struct packed {
    logic [SF_W-1:0]  sf;
    logic [BLK_W-1:0] blk;
    logic [BNO_W-1:0] bno;
  } ds3_pos_t;
endpackage

// File: rtl/ds3m_pos.sv
module ds3m_pos
  import ds3m_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bit_en,
  input  logic     frame_start,
  output ds3_pos_t cur_o,
  output logic     pos_ok_o,
  output logic     at_last_o,
  output logic     realign_o
);
  ds3_pos_t pos_q, pos_d;
  logic     locked_q, locked_d;

  always_comb begin
    cur_o     = frame_start ? '0 : pos_q;
    at_last_o = (cur_o.sf == SF_W'(SF_N-1)) && (cur_o.blk == BLK_W'(BLK_N-1)) &&
                (cur_o.bno == BNO_W'(BLK_BITS-1));
    pos_ok_o  = locked_q | frame_start;
    realign_o = frame_start & locked_q & (pos_q != '0);
    pos_d     = pos_q;
    locked_d  = locked_q;
    if (bit_en) begin
      locked_d = locked_q | frame_start;
      pos_d    = cur_o;
      if (cur_o.bno == BNO_W'(BLK_BITS-1)) begin
        pos_d.bno = '0;
        if (cur_o.blk == BLK_W'(BLK_N-1)) begin
          pos_d.blk = '0;
          pos_d.sf  = (cur_o.sf == SF_W'(SF_N-1)) ? '0 : cur_o.sf + SF_W'(1);
        end else begin
          pos_d.blk = cur_o.blk + BLK_W'(1);
        end
      end else begin
        pos_d.bno = cur_o.bno + BNO_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      pos_q    <= pos_d;
      locked_q <= locked_d;
    end
  end
endmodule

// File: rtl/ds3m_ovh.sv
module ds3m_ovh
  import ds3m_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bit_en,
  input  logic     bit_in,
  input  logic     cbit_mode,
  input  logic     fm_combined,
  input  ds3_pos_t cur,
  input  logic     pos_ok,
  input  logic     at_last,
  input  logic     realign,
  output logic     ev_frm,
  output logic     ev_par,
  output logic     ev_cp,
  output logic     ev_febe
);
  logic acc_q, acc_d, prev_q, prev_d, pv_q, pv_d;
  logic pflag_q, pflag_d, cpflag_q, cpflag_d, zflag_q, zflag_d;
  logic ok, oh, f_slot, m_slot, c_slot, exp_f, exp_m, mis_par;

  always_comb begin
    ok      = bit_en & pos_ok;
    oh      = (cur.bno == '0);
    f_slot  = ok & oh & cur.blk[0];
    m_slot  = ok & oh & (cur.blk == '0) & (cur.sf >= SF_W'(4));
    c_slot  = ok & oh & (cur.blk != '0) & ~cur.blk[0];
    exp_f   = (cur.blk == BLK_W'(1)) | (cur.blk == BLK_W'(7));
    exp_m   = (cur.sf == SF_W'(5));
    mis_par = bit_in ^ prev_q;

    ev_frm  = (f_slot & (bit_in ^ exp_f)) | (m_slot & fm_combined & (bit_in ^ exp_m));
    ev_par  = 1'b0;
    ev_cp   = 1'b0;
    ev_febe = 1'b0;

    acc_d    = acc_q;
    prev_d   = prev_q;
    pv_d     = pv_q;
    pflag_d  = pflag_q;
    cpflag_d = cpflag_q;
    zflag_d  = zflag_q;

    if (ok) begin
      if (realign) pv_d = 1'b0;
      if (!oh) acc_d = (frame_start_clear(cur) ? 1'b0 : acc_q) ^ bit_in;
      else if (cur == '0) acc_d = 1'b0;
      if (at_last) begin
        prev_d = acc_q ^ bit_in;
        acc_d  = 1'b0;
        pv_d   = 1'b1;
      end
      if (oh && cur.blk == '0 && cur.sf == SF_W'(2)) pflag_d = mis_par;
      if (oh && cur.blk == '0 && cur.sf == SF_W'(3)) ev_par = pv_q & (pflag_q | mis_par);
      if (c_slot && cur.sf == SF_W'(2)) begin
        cpflag_d = ((cur.blk == BLK_W'(2)) ? 1'b0 : cpflag_q) | mis_par;
        if (cur.blk == BLK_W'(6)) ev_cp = cbit_mode & pv_q & (cpflag_q | mis_par);
      end
      if (c_slot && cur.sf == SF_W'(3)) begin
        zflag_d = ((cur.blk == BLK_W'(2)) ? 1'b0 : zflag_q) | ~bit_in;
        if (cur.blk == BLK_W'(6)) ev_febe = cbit_mode & (zflag_q | ~bit_in);
      end
    end
  end

  function automatic logic frame_start_clear(input ds3_pos_t p);
    return (p.sf == '0) && (p.blk == '0) && (p.bno == BNO_W'(1));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= 1'b0;
      prev_q   <= 1'b0;
      pv_q     <= 1'b0;
      pflag_q  <= 1'b0;
      cpflag_q <= 1'b0;
      zflag_q  <= 1'b0;
    end else begin
      acc_q    <= acc_d;
      prev_q   <= prev_d;
      pv_q     <= pv_d;
      pflag_q  <= pflag_d;
      cpflag_q <= cpflag_d;
      zflag_q  <= zflag_d;
    end
  end
endmodule

// File: rtl/ds3m_satcnt.sv
module ds3m_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] shot_o
);
  localparam logic [W-1:0] MAX = '1;
  logic [W-1:0] cnt_d, shot_d;

  always_comb begin
    shot_d = shot_o;
    cnt_d  = cnt_o;
    if (clr) begin
      shot_d = cnt_o;
      cnt_d  = inc ? W'(1) : '0;
    end else if (inc && cnt_o != MAX) begin
      cnt_d  = cnt_o + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o  <= '0;
      shot_o <= '0;
    end else begin
      cnt_o  <= cnt_d;
      shot_o <= shot_d;
    end
  end
endmodule

// File: rtl/ds3_err_mon.sv
module ds3_err_mon
  import ds3m_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cbit_mode,
  input  logic          fm_combined,
  input  logic          bit_en,
  input  logic          bit_in,
  input  logic          frame_start,
  input  logic          lcv_pulse,
  input  logic          exz_pulse,
  input  logic          snap,
  output logic [CW-1:0] shot_lcv,
  output logic [CW-1:0] shot_exz,
  output logic [CW-1:0] shot_par,
  output logic [CW-1:0] shot_frm,
  output logic [CW-1:0] shot_febe,
  output logic [CW-1:0] shot_cp
);
  ds3_pos_t                  cur;
  logic                      pos_ok, at_last, realign;
  logic                      ev_frm, ev_par, ev_cp, ev_febe;
  logic [NUM_CNT-1:0]        ev;
  logic [NUM_CNT*CW-1:0]     cnt_flat, shot_flat;

  ds3m_pos u_pos (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
    .cur_o(cur), .pos_ok_o(pos_ok), .at_last_o(at_last), .realign_o(realign)
  );

  ds3m_ovh u_ovh (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .cbit_mode(cbit_mode), .fm_combined(fm_combined), .cur(cur),
    .pos_ok(pos_ok), .at_last(at_last), .realign(realign),
    .ev_frm(ev_frm), .ev_par(ev_par), .ev_cp(ev_cp), .ev_febe(ev_febe)
  );

  always_comb begin
    ev           = '0;
    ev[IDX_LCV]  = lcv_pulse;
    ev[IDX_EXZ]  = exz_pulse;
    ev[IDX_PAR]  = ev_par;
    ev[IDX_FRM]  = ev_frm;
    ev[IDX_FEBE] = ev_febe;
    ev[IDX_CP]   = ev_cp;
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    ds3m_satcnt #(.W(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(ev[i]), .clr(snap),
      .cnt_o(cnt_flat[i*CW +: CW]), .shot_o(shot_flat[i*CW +: CW])
    );
  end

  assign shot_lcv  = shot_flat[IDX_LCV*CW  +: CW];
  assign shot_exz  = shot_flat[IDX_EXZ*CW  +: CW];
  assign shot_par  = shot_flat[IDX_PAR*CW  +: CW];
  assign shot_frm  = shot_flat[IDX_FRM*CW  +: CW];
  assign shot_febe = shot_flat[IDX_FEBE*CW +: CW];
  assign shot_cp   = shot_flat[IDX_CP*CW   +: CW];
endmodule

// File: rtl/ds3m_sva.sv
module ds3m_sva
  import ds3m_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  snap,
  input logic                  cbit_mode,
  input logic                  bit_en,
  input logic [NUM_CNT-1:0]    ev,
  input logic [NUM_CNT*CW-1:0] cnt_flat,
  input logic [NUM_CNT*CW-1:0] shot_flat
);
  localparam logic [CW-1:0] MAX = '1;

  p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(shot_flat));

  p_m13_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cbit_mode |-> (!ev[IDX_CP] && !ev[IDX_FEBE]));

  p_oh_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[IDX_FRM] || ev[IDX_PAR] || ev[IDX_CP] || ev[IDX_FEBE]) |-> bit_en);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_flat[i*CW +: CW] == MAX && !snap) |=> (cnt_flat[i*CW +: CW] == MAX));

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!snap && !ev[i]) |=> $stable(cnt_flat[i*CW +: CW]));

    p_clear_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      snap |=> (cnt_flat[i*CW +: CW] == {{(CW-1){1'b0}}, $past(ev[i])}));
  end
endmodule

bind ds3_err_mon ds3m_sva #(.CW(CW)) u_sva (
  .clk(clk), .rst_n(rst_n), .snap(snap), .cbit_mode(cbit_mode),
  .bit_en(bit_en), .ev(ev), .cnt_flat(cnt_flat), .shot_flat(shot_flat)
);

// File: tb/sim_ds3_err_mon.sv
`timescale 1ns/1ps
module sim_ds3_err_mon;
  logic clk = 1'b0;
  logic rst_n, cbit_mode, fm_combined, bit_en, bit_in, frame_start;
  logic lcv_pulse, exz_pulse, snap;
  logic [15:0] shot_lcv, shot_exz, shot_par, shot_frm, shot_febe, shot_cp;

  int   n_tests = 0, n_fail = 0;
  int   e_frm = 0, e_par = 0, e_cp = 0, e_febe = 0;
  int   frames_locked = 0;
  logic bpar = 1'b0;
  logic [15:0] lf = 16'hACE1;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  ds3_err_mon u0 (
    .clk(clk), .rst_n(rst_n), .cbit_mode(cbit_mode), .fm_combined(fm_combined),
    .bit_en(bit_en), .bit_in(bit_in), .frame_start(frame_start),
    .lcv_pulse(lcv_pulse), .exz_pulse(exz_pulse), .snap(snap),
    .shot_lcv(shot_lcv), .shot_exz(shot_exz), .shot_par(shot_par),
    .shot_frm(shot_frm), .shot_febe(shot_febe), .shot_cp(shot_cp)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_snap();
    @(negedge clk); snap = 1'b1;
    @(negedge clk); snap = 1'b0;
  endtask

  task automatic check_frame_counts(input string tag);
    do_snap();
    check({tag, " R3 R4 framing"}, int'(shot_frm), e_frm);
    check({tag, " R5 parity"},     int'(shot_par), e_par);
    check({tag, " R6 R8 cp"},      int'(shot_cp), e_cp);
    check({tag, " R7 R8 febe"},    int'(shot_febe), e_febe);
    check({tag, " R2 lcv idle"},   int'(shot_lcv), 0);
    e_frm = 0; e_par = 0; e_cp = 0; e_febe = 0;
  endtask

  task automatic send_frame(input logic cb, input logic comb, input logic [1:0] pbad,
                            input logic [3:0] fbad, input logic [2:0] mbad,
                            input logic [2:0] cpbad, input logic febez, input logic gaps);
    logic acc = 1'b0;
    cbit_mode = cb; fm_combined = comb;
    for (int i = 0; i < 4760; i++) begin
      int sf = i / 680;
      int blk = (i % 680) / 85;
      int b = i % 85;
      logic v;
      if (b != 0) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        v = lf[0];
        acc ^= v;
      end else if (blk == 0) begin
        if (sf < 2)      v = 1'b1;
        else if (sf < 4) v = bpar ^ pbad[sf-2];
        else             v = (sf == 5) ^ mbad[sf-4];
      end else if (blk % 2 == 1) begin
        v = (blk == 1) || (blk == 7);
        if (sf == 0) v ^= fbad[blk/2];
      end else begin
        if (sf == 2)      v = bpar ^ cpbad[blk/2-1];
        else if (sf == 3) v = !(febez && blk == 4);
        else              v = 1'b1;
      end
      if (gaps && (i % 97 == 5)) begin
        @(negedge clk); bit_en = 1'b0; frame_start = 1'b0; bit_in = ~v;
      end
      @(negedge clk); bit_en = 1'b1; bit_in = v; frame_start = (i == 0);
    end
    @(negedge clk); bit_en = 1'b0; frame_start = 1'b0;
    e_frm += $countones(fbad) + (comb ? $countones(mbad) : 0);
    if (frames_locked > 0 && |pbad) e_par++;
    if (cb && frames_locked > 0 && |cpbad) e_cp++;
    if (cb && febez) e_febe++;
    bpar = acc;
    frames_locked++;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cbit_mode = 1'b0; fm_combined = 1'b0; bit_en = 1'b0; bit_in = 1'b0;
    frame_start = 1'b0; lcv_pulse = 1'b0; exz_pulse = 1'b0; snap = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset lcv",  int'(shot_lcv), 0);
    check("R9 reset exz",  int'(shot_exz), 0);
    check("R9 reset par",  int'(shot_par), 0);
    check("R9 reset frm",  int'(shot_frm), 0);
    check("R9 reset febe", int'(shot_febe), 0);
    check("R9 reset cp",   int'(shot_cp), 0);

    // R10: data before the first marker must not be checked (all zero bits)
    repeat (200) begin @(negedge clk); bit_en = 1'b1; bit_in = 1'b0; end
    @(negedge clk); bit_en = 1'b0;

    // M13 format, F only; first frame exempt from parity (R5), C bits ignored (R8)
    send_frame(1'b0, 1'b0, 2'b11, 4'b0000, 3'b000, 3'b111, 1'b1, 1'b0);
    send_frame(1'b0, 1'b0, 2'b01, 4'b0101, 3'b010, 3'b001, 1'b1, 1'b0);
    check_frame_counts("m13 R10");

    // C-bit parity format, F and M combined
    send_frame(1'b1, 1'b1, 2'b00, 4'b1000, 3'b100, 3'b101, 1'b0, 1'b0);
    send_frame(1'b1, 1'b1, 2'b10, 4'b0000, 3'b000, 3'b000, 1'b1, 1'b1);
    send_frame(1'b1, 1'b0, 2'b00, 4'b0000, 3'b111, 3'b010, 1'b0, 1'b1);
    check_frame_counts("cbit R10 gaps");

    // R2: pulse counting
    repeat (5) begin @(negedge clk); lcv_pulse = 1'b1; exz_pulse = 1'b1; end
    repeat (2) begin @(negedge clk); lcv_pulse = 1'b0; exz_pulse = 1'b1; end
    @(negedge clk); lcv_pulse = 1'b0; exz_pulse = 1'b0;
    do_snap();
    check("R2 lcv count", int'(shot_lcv), 5);
    check("R2 exz count", int'(shot_exz), 7);

    // R9: event in the snap cycle goes into the next interval
    repeat (3) begin @(negedge clk); lcv_pulse = 1'b1; end
    @(negedge clk); lcv_pulse = 1'b1; snap = 1'b1;
    @(negedge clk); lcv_pulse = 1'b0; snap = 1'b0;
    check("R9 snap excludes same-cycle event", int'(shot_lcv), 3);
    check("R9 cleared exz", int'(shot_exz), 0);
    do_snap();
    check("R9 same-cycle event kept", int'(shot_lcv), 1);

    // R1: saturation
    for (int k = 0; k < 65540; k++) begin @(negedge clk); lcv_pulse = 1'b1; end
    @(negedge clk); lcv_pulse = 1'b0;
    do_snap();
    check("R1 saturate at 0xFFFF", int'(shot_lcv), 65535);
    do_snap();
    check("R1 restart after saturation", int'(shot_lcv), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule